// File: doc/BRIEF.md
# Two-Lane Ordered Stream Merger

This block joins two timestamp-ordered sample streams into one ordered stream while moving two samples per clock, so the core clock needs to run at only half the output sample rate (for example 160 MHz for 320 million samples per second out). Each input is the show-ahead read side of a double-width FIFO whose words hold two consecutive samples of one stream. The output is the write side of a double-width FIFO that can push back with a full flag.

Each side keeps up to two pending samples in a small staging register. The block looks at the staged samples together with the word at the FIFO head, picks the two oldest of both sides and writes them as one word. A word can be consumed in part, and its remainder stays staged for the next cycle. Samples are 32 bits. The ordering key is the upper `KEY_W` bits of a sample, compared as unsigned numbers. The low bits travel with the sample unchanged. Each side also has an end-of-stream flag. After one side has ended, the other side's samples go straight through in pairs.

A control state machine has four states. `ST_MERGE` compares both sides. `ST_PASS_A` runs only side A once side B is exhausted, and `ST_PASS_B` is its mirror. `ST_DONE` is entered when both sides are exhausted and stays until reset. A side is exhausted when its end flag is high, its FIFO is empty and nothing is staged. The transitions are:
- `T_BOTH_END` (from any state): both sides exhausted, go to `ST_DONE`.
- `T_B_END` (`ST_MERGE` to `ST_PASS_A`): side B exhausted.
- `T_A_END` (`ST_MERGE` to `ST_PASS_B`): side A exhausted.
- `T_TAIL_END` (`ST_PASS_A` or `ST_PASS_B` to `ST_DONE`): the remaining side is exhausted.

Top module: `pair_stream_merger`

## Requirements
- R1: Lane 0 (bits [31:0]) of every input and output word holds the older sample and lane 1 (bits [63:32]) the newer. The keys written across all outputs form the non-decreasing merge of both inputs.
- R2: When keys are equal, the sample from input A leaves before the sample from input B.
- R3: While `o_full` is high, `o_wr`, `a_rd` and `b_rd` stay low in the same cycle.
- R4: A read strobe (`a_rd`/`b_rd`) is raised only while that side's `*_valid` is high. A word with `*_single` set carries only its lane-0 sample.
- R5: Nothing is written while a side that has not ended has neither staged nor offered samples (its `*_valid` and `*_last` are both low and nothing is staged), because the oldest pair cannot be proven.
- R6: Every write except a final odd one carries two samples, so the number of writes is ceil(total/2).
- R7: Only when the total sample count is odd, the last write has `o_lane1_vld` low, and the end flags of both sides are high at that time.
- R8: `merge_done` rises once both sides are exhausted. It then stays high and no further write occurs.
- R9: During reset, `o_wr`, `a_rd`, `b_rd` and `merge_done` are low.
- R10: Every input sample is written exactly once. No sample is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_data | input | 64 | Head word of input FIFO A, two samples |
| a_single | input | 1 | Head word A carries only its lane-0 sample |
| a_valid | input | 1 | FIFO A is not empty |
| a_last | input | 1 | No words will be added to FIFO A beyond those it holds |
| a_rd | output | 1 | Pop the head word of FIFO A |
| b_data | input | 64 | Head word of input FIFO B, two samples |
| b_single | input | 1 | Head word B carries only its lane-0 sample |
| b_valid | input | 1 | FIFO B is not empty |
| b_last | input | 1 | No words will be added to FIFO B beyond those it holds |
| b_rd | output | 1 | Pop the head word of FIFO B |
| o_data | output | 64 | Output word, lane 0 older |
| o_lane1_vld | output | 1 | Lane 1 of `o_data` holds a sample |
| o_wr | output | 1 | Write `o_data` into the output FIFO |
| o_full | input | 1 | Output FIFO is full |
| merge_done | output | 1 | Both streams fully merged |

## Verification
`o_wr`, `o_data`, `o_lane1_vld` and the read strobes are combinational from the staged samples and the FIFO heads, so they are due in the same cycle in which the inputs are presented. The bench samples them at the falling edge and moves its FIFO models only after the following rising edge. The effect of a pop shows on the FIFO head one cycle later. `merge_done` comes one rising edge after both sides become exhausted. For that reason the bench waits for it with a bound and then watches a few more cycles for stray writes. The sweep covers stream lengths of 0 to 5 samples per side, key offsets that create ties, three backpressure patterns and a delayed start of side B. The expected sequence is built by a two-pointer merge with A first on ties.

// File: rtl/merge_pkg.sv
package merge_pkg;

    typedef enum logic [1:0] {
        ST_MERGE  = 2'd0,
        ST_PASS_A = 2'd1,
        ST_PASS_B = 2'd2,
        ST_DONE   = 2'd3
    } merge_state_t;

    typedef logic [1:0] lane_cnt_t;

endpackage

// File: rtl/merge_side_stage.sv
module merge_side_stage #(
    parameter int SAMPLE_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*SAMPLE_W-1:0] word,
    input  logic                  single,
    input  logic                  valid,
    input  logic                  last,
    input  logic                  enable,
    input  logic                  hold,
    input  logic                  commit,
    input  logic [1:0]            take,
    output logic [SAMPLE_W-1:0]   view0,
    output logic [SAMPLE_W-1:0]   view1,
    output logic [1:0]            view_cnt,
    output logic                  ready,
    output logic                  exhausted,
    output logic                  rd
);
    localparam int CW = 3;

    logic [SAMPLE_W-1:0] slot0, slot1;
    logic [1:0]          cnt;
    logic [SAMPLE_W-1:0] w_lo, w_hi;
    logic [CW-1:0]       word_n, offer, sum, fill, taken, after_cnt;
    logic [SAMPLE_W-1:0] nxt0, nxt1;

    assign w_lo = word[SAMPLE_W-1:0];
    assign w_hi = word[2*SAMPLE_W-1:SAMPLE_W];

    // Staged samples come first, then the head word's lanes.
    function automatic logic [SAMPLE_W-1:0] pick_item(
        input logic [CW-1:0]       idx,
        input logic [1:0]          c,
        input logic [SAMPLE_W-1:0] s0,
        input logic [SAMPLE_W-1:0] s1,
        input logic [SAMPLE_W-1:0] w0,
        input logic [SAMPLE_W-1:0] w1
    );
        logic [CW-1:0] off;
        off = idx - {1'b0, c};
        if (idx < {1'b0, c}) begin
            return idx[0] ? s1 : s0;
        end
        return off[0] ? w1 : w0;
    endfunction

    always_comb begin
        word_n   = single ? 3'd1 : 3'd2;
        offer    = (enable && valid) ? word_n : 3'd0;
        sum      = {1'b0, cnt} + offer;
        view_cnt = (sum >= 3'd2) ? 2'd2 : sum[1:0];
        view0    = pick_item(3'd0, cnt, slot0, slot1, w_lo, w_hi);
        view1    = pick_item(3'd1, cnt, slot0, slot1, w_lo, w_hi);
        ready    = !enable || (view_cnt == 2'd2) || (last && !valid);
        exhausted = !enable || (last && !valid && (cnt == 2'd0));
        taken    = commit ? {1'b0, take} : 3'd0;
        fill     = {1'b0, cnt} + word_n;
        rd       = enable && valid && !hold && ((fill - taken) <= 3'd2);
        after_cnt = (rd ? fill : {1'b0, cnt}) - taken;
        nxt0     = pick_item(taken,        cnt, slot0, slot1, w_lo, w_hi);
        nxt1     = pick_item(taken + 3'd1, cnt, slot0, slot1, w_lo, w_hi);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= 2'd0;
            slot0 <= '0;
            slot1 <= '0;
        end else begin
            cnt   <= after_cnt[1:0];
            slot0 <= nxt0;
            slot1 <= nxt1;
        end
    end

endmodule

// File: rtl/merge_pair_pick.sv
module merge_pair_pick #(
    parameter int SAMPLE_W = 32,
    parameter int KEY_W    = 24
) (
    input  logic [SAMPLE_W-1:0] a0,
    input  logic [SAMPLE_W-1:0] a1,
    input  logic [1:0]          ca,
    input  logic [SAMPLE_W-1:0] b0,
    input  logic [SAMPLE_W-1:0] b1,
    input  logic [1:0]          cb,
    input  logic                ready_a,
    input  logic                ready_b,
    input  logic                active,
    input  logic                full,
    output logic                fire,
    output logic [1:0]          take_a,
    output logic [1:0]          take_b,
    output logic [SAMPLE_W-1:0] lane0,
    output logic [SAMPLE_W-1:0] lane1,
    output logic                lane1_vld
);
    localparam int KEY_LSB = SAMPLE_W - KEY_W;

    logic                first_a, has_first, has_na, has_nb, second_a, has_second;
    logic [SAMPLE_W-1:0] na, nb;
    logic [1:0]          sec_a, sec_b;

    function automatic logic [KEY_W-1:0] key_of(input logic [SAMPLE_W-1:0] s);
        return s[SAMPLE_W-1:KEY_LSB];
    endfunction

    always_comb begin
        has_first  = (ca != 2'd0) || (cb != 2'd0);
        first_a    = (ca != 2'd0) && ((cb == 2'd0) || (key_of(a0) <= key_of(b0)));
        na         = first_a ? a1 : a0;
        nb         = first_a ? b0 : b1;
        has_na     = first_a ? (ca == 2'd2) : (ca != 2'd0);
        has_nb     = first_a ? (cb != 2'd0) : (cb == 2'd2);
        second_a   = has_na && (!has_nb || (key_of(na) <= key_of(nb)));
        has_second = has_na || has_nb;
        lane0      = first_a ? a0 : b0;
        lane1      = second_a ? na : nb;
        lane1_vld  = has_second;
        fire       = active && ready_a && ready_b && !full && has_first;
        sec_a      = (has_second && second_a)  ? 2'd1 : 2'd0;
        sec_b      = (has_second && !second_a) ? 2'd1 : 2'd0;
        take_a     = fire ? ((first_a ? 2'd1 : 2'd0) + sec_a) : 2'd0;
        take_b     = fire ? ((first_a ? 2'd0 : 2'd1) + sec_b) : 2'd0;
    end

endmodule

// File: rtl/merge_ctrl.sv
module merge_ctrl
    import merge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_exh,
    input  logic b_exh,
    output logic en_a,
    output logic en_b,
    output logic active,
    output logic done
);
    merge_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_MERGE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_MERGE: begin
                if (a_exh && b_exh)  state_nxt = ST_DONE;   // T_BOTH_END
                else if (b_exh)      state_nxt = ST_PASS_A; // T_B_END
                else if (a_exh)      state_nxt = ST_PASS_B; // T_A_END
            end
            ST_PASS_A: if (a_exh) state_nxt = ST_DONE;      // T_TAIL_END
            ST_PASS_B: if (b_exh) state_nxt = ST_DONE;      // T_TAIL_END
            ST_DONE:   state_nxt = ST_DONE;
        endcase
    end

    always_comb begin
        en_a = 1'b0; en_b = 1'b0; active = 1'b0; done = 1'b0;
        unique case (state)
            ST_MERGE:  begin en_a = 1'b1; en_b = 1'b1; active = 1'b1; end
            ST_PASS_A: begin en_a = 1'b1; active = 1'b1; end
            ST_PASS_B: begin en_b = 1'b1; active = 1'b1; end
            ST_DONE:   done = 1'b1;
        endcase
    end

endmodule

// File: rtl/pair_stream_merger.sv
module pair_stream_merger #(
    parameter int SAMPLE_W = 32,
    parameter int KEY_W    = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*SAMPLE_W-1:0] a_data,
    input  logic                  a_single,
    input  logic                  a_valid,
    input  logic                  a_last,
    output logic                  a_rd,
    input  logic [2*SAMPLE_W-1:0] b_data,
    input  logic                  b_single,
    input  logic                  b_valid,
    input  logic                  b_last,
    output logic                  b_rd,
    output logic [2*SAMPLE_W-1:0] o_data,
    output logic                  o_lane1_vld,
    output logic                  o_wr,
    input  logic                  o_full,
    output logic                  merge_done
);
    logic                en_a, en_b, active, done;
    logic [SAMPLE_W-1:0] av0, av1, bv0, bv1, lane0, lane1;
    logic [1:0]          ca, cb, take_a, take_b;
    logic                rdy_a, rdy_b, exh_a, exh_b, fire, l1v;

    merge_side_stage #(.SAMPLE_W(SAMPLE_W)) side_a_i (
        .clk(clk), .rst_n(rst_n), .word(a_data), .single(a_single),
        .valid(a_valid), .last(a_last), .enable(en_a), .hold(o_full),
        .commit(fire), .take(take_a), .view0(av0), .view1(av1),
        .view_cnt(ca), .ready(rdy_a), .exhausted(exh_a), .rd(a_rd)
    );

    merge_side_stage #(.SAMPLE_W(SAMPLE_W)) side_b_i (
        .clk(clk), .rst_n(rst_n), .word(b_data), .single(b_single),
        .valid(b_valid), .last(b_last), .enable(en_b), .hold(o_full),
        .commit(fire), .take(take_b), .view0(bv0), .view1(bv1),
        .view_cnt(cb), .ready(rdy_b), .exhausted(exh_b), .rd(b_rd)
    );

    merge_pair_pick #(.SAMPLE_W(SAMPLE_W), .KEY_W(KEY_W)) pick_i (
        .a0(av0), .a1(av1), .ca(ca), .b0(bv0), .b1(bv1), .cb(cb),
        .ready_a(rdy_a), .ready_b(rdy_b), .active(active), .full(o_full),
        .fire(fire), .take_a(take_a), .take_b(take_b),
        .lane0(lane0), .lane1(lane1), .lane1_vld(l1v)
    );

    merge_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .a_exh(exh_a), .b_exh(exh_b),
        .en_a(en_a), .en_b(en_b), .active(active), .done(done)
    );

    assign o_wr        = fire;
    assign o_lane1_vld = fire && l1v;
    assign o_data      = {(l1v ? lane1 : {SAMPLE_W{1'b0}}), lane0};
    assign merge_done  = done;

endmodule

// File: rtl/pair_stream_merger_chk.sv
module pair_stream_merger_chk #(
    parameter int SAMPLE_W = 32,
    parameter int KEY_W    = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  a_valid,
    input logic                  a_last,
    input logic                  a_rd,
    input logic                  b_valid,
    input logic                  b_last,
    input logic                  b_rd,
    input logic [2*SAMPLE_W-1:0] o_data,
    input logic                  o_lane1_vld,
    input logic                  o_wr,
    input logic                  o_full,
    input logic                  merge_done
);
    logic [KEY_W-1:0] lo_key, hi_key, prev_key;
    logic             have_prev;

    assign lo_key = o_data[SAMPLE_W-1 -: KEY_W];
    assign hi_key = o_data[2*SAMPLE_W-1 -: KEY_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_key  <= '0;
            have_prev <= 1'b0;
        end else if (o_wr) begin
            prev_key  <= o_lane1_vld ? hi_key : lo_key;
            have_prev <= 1'b1;
        end
    end

    p_lane_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (o_wr && o_lane1_vld) |-> (lo_key <= hi_key));
    p_monotonic_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (o_wr && have_prev) |-> (lo_key >= prev_key));
    p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        o_full |-> (!o_wr && !a_rd && !b_rd));
    p_rd_a_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd |-> a_valid);
    p_rd_b_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        b_rd |-> b_valid);
    p_odd_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_wr && !o_lane1_vld) |-> (a_last && b_last));
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        merge_done |-> !o_wr);
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        merge_done |=> merge_done);

endmodule

bind pair_stream_merger pair_stream_merger_chk #(.SAMPLE_W(SAMPLE_W), .KEY_W(KEY_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_last(a_last), .a_rd(a_rd),
    .b_valid(b_valid), .b_last(b_last), .b_rd(b_rd), .o_data(o_data),
    .o_lane1_vld(o_lane1_vld), .o_wr(o_wr), .o_full(o_full), .merge_done(merge_done)
);

// File: tb/pair_stream_merger_tb_top.sv
`timescale 1ns/1ps
module pair_stream_merger_tb_top;
    localparam int W = 32;
    localparam int K = 24;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic [2*W-1:0] a_data, b_data, o_data;
    logic a_single, a_valid, a_last, a_rd;
    logic b_single, b_valid, b_last, b_rd;
    logic o_lane1_vld, o_wr, o_full, merge_done;

    pair_stream_merger #(.SAMPLE_W(W), .KEY_W(K)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_data(a_data), .a_single(a_single), .a_valid(a_valid), .a_last(a_last), .a_rd(a_rd),
        .b_data(b_data), .b_single(b_single), .b_valid(b_valid), .b_last(b_last), .b_rd(b_rd),
        .o_data(o_data), .o_lane1_vld(o_lane1_vld), .o_wr(o_wr), .o_full(o_full),
        .merge_done(merge_done)
    );

    int tests = 0;
    int fails = 0;
    logic [W-1:0] amem [8];
    logic [W-1:0] bmem [8];
    logic [W-1:0] got  [16];
    logic [W-1:0] expv [16];
    int na_s, nb_s, wa, wb, cyc, dly, bp;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (na=%0d nb=%0d bp=%0d dly=%0d)",
                     req, what, act, exp, na_s, nb_s, bp, dly);
        end
    endtask

    function automatic logic [W-1:0] mk(input int key, input bit side, input int idx);
        logic [K-1:0] k;
        logic [6:0]   ix;
        k  = K'(key);
        ix = 7'(idx);
        return {k, side, ix};
    endfunction

    task automatic drive_idle();
        a_data = '0; a_single = 1'b0; a_valid = 1'b0; a_last = 1'b0;
        b_data = '0; b_single = 1'b0; b_valid = 1'b0; b_last = 1'b0;
        o_full = 1'b0;
    endtask

    task automatic drive();
        a_valid  = (wa < (na_s + 1) / 2);
        a_last   = 1'b1;
        a_single = a_valid && (2 * wa + 1 >= na_s);
        a_data   = '0;
        if (a_valid) a_data = {(a_single ? '0 : amem[2*wa+1]), amem[2*wa]};
        b_valid  = (cyc >= dly) && (wb < (nb_s + 1) / 2);
        b_last   = (cyc >= dly);
        b_single = b_valid && (2 * wb + 1 >= nb_s);
        b_data   = '0;
        if (b_valid) b_data = {(b_single ? '0 : bmem[2*wb+1]), bmem[2*wb]};
        case (bp)
            1:       o_full = (cyc % 2) == 1;
            2:       o_full = (cyc % 3) != 0;
            default: o_full = 1'b0;
        endcase
    endtask

    task automatic run_case(input int na, input int nb, input int offa, input int offb,
                            input int bpat, input int delay, input bit check_reset);
        int ia, ib, tot, ngot, nwr, nodd, post, guard;
        bit seen_done, a_pop, b_pop;
        na_s = na; nb_s = nb; bp = bpat; dly = delay;
        for (int i = 0; i < 8; i++) begin
            amem[i] = mk(3 * i + offa + 1, 1'b0, i);
            bmem[i] = mk(2 * i + offb, 1'b1, i);
        end
        // reference merge, A first on equal keys
        ia = 0; ib = 0; tot = 0;
        while (ia < na || ib < nb) begin
            if (ib >= nb || (ia < na && amem[ia][W-1 -: K] <= bmem[ib][W-1 -: K])) begin
                expv[tot] = amem[ia]; ia++;
            end else begin
                expv[tot] = bmem[ib]; ib++;
            end
            tot++;
        end
        rst_n = 1'b0; drive_idle();
        repeat (2) @(negedge clk);
        if (check_reset) begin
            chk(!o_wr, "R9", "o_wr in reset", o_wr, 0);
            chk(!a_rd && !b_rd, "R9", "read strobes in reset", {a_rd, b_rd}, 0);
            chk(!merge_done, "R9", "merge_done in reset", merge_done, 0);
        end
        @(posedge clk); #1;
        rst_n = 1'b1; wa = 0; wb = 0; cyc = 0; drive();
        ngot = 0; nwr = 0; nodd = 0; post = 0; guard = 0; seen_done = 1'b0;
        while (guard < 150) begin
            @(negedge clk);
            if (o_full) chk(!o_wr && !a_rd && !b_rd, "R3", "activity while full",
                            {o_wr, a_rd, b_rd}, 0);
            if (a_rd) chk(a_valid, "R4", "a_rd on empty", a_valid, 1);
            if (b_rd) chk(b_valid, "R4", "b_rd on empty", b_valid, 1);
            if (dly > 0 && cyc < dly) chk(!o_wr, "R5", "write without proof", o_wr, 0);
            if (seen_done) chk(!o_wr, "R8", "write after done", o_wr, 0);
            if (o_wr) begin
                nwr++;
                if (ngot < 16) got[ngot] = o_data[W-1:0];
                ngot++;
                if (o_lane1_vld) begin
                    if (ngot < 16) got[ngot] = o_data[2*W-1:W];
                    ngot++;
                end else begin
                    nodd++;
                    chk(ngot == tot && (tot % 2) == 1, "R7", "half write position", ngot, tot);
                end
            end
            a_pop = a_rd; b_pop = b_rd;
            if (merge_done) begin
                seen_done = 1'b1;
                post++;
                if (post == 3) break;
            end
            @(posedge clk); #1;
            if (a_pop) wa++;
            if (b_pop) wb++;
            cyc++; guard++;
            drive();
        end
        chk(seen_done, "R8", "merge_done reached", seen_done, 1);
        chk(ngot == tot, "R10", "sample count", ngot, tot);
        chk(nwr == (tot + 1) / 2, "R6", "write count", nwr, (tot + 1) / 2);
        chk(nodd == tot % 2, "R7", "half writes", nodd, tot % 2);
        for (int i = 0; i < tot && i < ngot && i < 16; i++)
            chk(got[i] == expv[i], "R1/R2", "merged sample", got[i], expv[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit first;
        first = 1'b1;
        drive_idle();
        rst_n = 1'b0;
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < 3; p++)
                for (int oa = 0; oa < 2; oa++)
                    for (int ob = 0; ob < 2; ob++)
                        for (int na = 0; na < 6; na++)
                            for (int nb = 0; nb < 6; nb++) begin
                                run_case(na, nb, oa, ob, p, d * 3, first);
                                first = 1'b0;
                            end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule